// File: doc/BRIEF.md
# Playback Byte FIFO with Host Polling Flags

This block sits between a host that writes playback audio one byte at a time over a programmed-I/O port and a DAC path that consumes one 32-bit stereo frame per sample period. Bytes go into a 64-byte FIFO. On every sample tick the block hands one frame to the DAC side, but only a frame whose four bytes are all present. Two 16-bit channels make up each frame.

The host paces its writes by polling combinational flags. One flag says whether there is room for a whole frame. One says whether the FIFO is at least half empty. Two more say which byte position and which channel the next write will fill. The last is a sticky underrun flag.

If a tick finds no complete frame, the DAC side still gets a frame. A configuration input picks what that frame holds: silence (mid-scale, which is zero for signed samples) or a repeat of the last real frame. The underrun flag rises when this happens and stays up until the host finishes its next full four-byte frame.

Top module: `pb_fifo_pio`

## Requirements
- R1: Out of reset the FIFO is empty. `room_ok`=1, `half_room`=1, `need_upper`=0, `need_left`=1, `underrun`=0, `frame_valid`=0 and `frame_out`=0.
- R2: Accepted bytes form frames in this order: left low, left high, right low, right high. A released frame has the left sample `{high,low}` in bits [31:16] and the right sample `{high,low}` in bits [15:0].
- R3: `room_ok` is 1 exactly when at least 4 bytes are free in the 64-byte FIFO.
- R4: `half_room` is 1 exactly when at least 32 bytes are free.
- R5: `need_upper` is 0 when the next byte is a low byte and 1 when it is a high byte, that is after an odd number of accepted bytes within the current frame.
- R6: `need_left` is 1 while the next byte belongs to the left channel (frame positions 0 and 1) and 0 for the right channel (positions 2 and 3).
- R7: A write strobe while the FIFO holds 64 bytes is ignored. Flags and stored contents do not change.
- R8: Every `tick` produces a one-cycle `frame_valid` on the next cycle. When at least one complete frame is stored, the oldest one is removed and appears on `frame_out` with that strobe.
- R9: A `tick` that finds no complete frame sets `underrun`, and the flag stays set.
- R10: `underrun` clears when an accepted write completes a frame (fourth byte). If this happens in the same cycle as an R9 event, the clear wins.
- R11: With `repeat_mode`=0, a tick without a complete frame outputs 0x00000000.
- R12: With `repeat_mode`=1, a tick without a complete frame outputs the last frame that was actually released from the FIFO (0 if none since reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| tick | input | 1 | Sample-period tick |
| repeat_mode | input | 1 | Starved-tick fallback: 0 mid-scale, 1 repeat last frame |
| room_ok | output | 1 | At least 4 bytes free |
| half_room | output | 1 | At least 32 bytes free |
| need_upper | output | 1 | Next byte is a high byte |
| need_left | output | 1 | Next byte is for the left channel |
| underrun | output | 1 | Sticky starvation flag |
| frame_out | output | 32 | Stereo frame to the DAC side |
| frame_valid | output | 1 | Frame strobe, one cycle after each tick |

## Verification
A slip in the byte-position counter shows at once in `need_upper` or `need_left` after the next write. At the next tick it also shows as swapped halves in `frame_out`. An error in the occupancy count appears within a write or two at `room_ok` or `half_room`, or at a tick as a frame released too early or withheld. An underrun bug shows on `underrun` in the cycle after the tick or the completing write. A fallback error shows on `frame_out` in that same cycle.

// File: rtl/pb_fifo_pio.sv
module pb_fifo_pio #(
  parameter int DEPTH = 64,
  parameter int HALF  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        tick,
  input  logic        repeat_mode,
  output logic        room_ok,
  output logic        half_room,
  output logic        need_upper,
  output logic        need_left,
  output logic        underrun,
  output logic [31:0] frame_out,
  output logic        frame_valid
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt, free;
  logic [1:0]    wpos;
  logic [31:0]   last_frame, head;
  logic          push, pop, fin;

  logic [AW-1:0] r1, r2, r3;
  assign r1 = rptr + AW'(1);
  assign r2 = rptr + AW'(2);
  assign r3 = rptr + AW'(3);
  assign head = {mem[r1], mem[rptr], mem[r3], mem[r2]};

  assign push = wr_en && (cnt != FULL);
  assign pop  = tick && (cnt >= (AW+1)'(4));
  assign fin  = push && (wpos == 2'd3);
  assign free = FULL - cnt;

  assign room_ok    = free >= (AW+1)'(4);
  assign half_room  = free >= (AW+1)'(HALF);
  assign need_upper = wpos[0];
  assign need_left  = ~wpos[1];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      wpos <= '0;
    end else begin
      if (push) begin
        wptr <= wptr + AW'(1);
        wpos <= wpos + 2'd1;
      end
      if (pop) rptr <= rptr + AW'(4);
      cnt <= cnt + (push ? (AW+1)'(1) : '0) - (pop ? (AW+1)'(4) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_out   <= '0;
      last_frame  <= '0;
      frame_valid <= 1'b0;
      underrun    <= 1'b0;
    end else begin
      frame_valid <= tick;
      if (pop) begin
        frame_out  <= head;
        last_frame <= head;
      end else if (tick) begin
        frame_out  <= repeat_mode ? last_frame : 32'h0;
      end
      if (fin)
        underrun <= 1'b0;
      else if (tick && !pop)
        underrun <= 1'b1;
    end
  end
endmodule

module pb_fifo_pio_chk #(
  parameter int AW = 6,
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        tick,
  input logic        repeat_mode,
  input logic        need_upper,
  input logic        need_left,
  input logic        underrun,
  input logic        frame_valid,
  input logic [31:0] frame_out,
  input logic [AW:0] cnt
);
  assert_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> frame_valid);
  assert_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !frame_valid);
  assert_full_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == (AW+1)'(DEPTH) && !tick) |=> $stable(cnt));
  assert_clear_on_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && need_upper && !need_left) |=> !underrun);
  assert_set_on_starve_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt < (AW+1)'(4) && !(wr_en && need_upper && !need_left)) |=> underrun);
  assert_midscale_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt < (AW+1)'(4) && !repeat_mode) |=> frame_out == 32'h0);
endmodule

bind pb_fifo_pio pb_fifo_pio_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick),
  .repeat_mode(repeat_mode), .need_upper(need_upper), .need_left(need_left),
  .underrun(underrun), .frame_valid(frame_valid), .frame_out(frame_out),
  .cnt(cnt)
);

// File: tb/pb_fifo_pio_test.sv
module pb_fifo_pio_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, tick = 1'b0, repeat_mode = 1'b0;
  logic [7:0] wr_data = 8'h0;
  logic room_ok, half_room, need_upper, need_left, underrun, frame_valid;
  logic [31:0] frame_out;

  always #4 clk = ~clk;

  pb_fifo_pio uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
    .repeat_mode(repeat_mode), .room_ok(room_ok), .half_room(half_room),
    .need_upper(need_upper), .need_left(need_left), .underrun(underrun),
    .frame_out(frame_out), .frame_valid(frame_valid)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] q[$];
  int mpos = 0;
  logic m_un = 0, m_fv = 0;
  logic [31:0] m_frame = 0, m_last = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit exp_room();  return (64 - q.size()) >= 4;  endfunction
  function automatic bit exp_half();  return (64 - q.size()) >= 32; endfunction

  task automatic check_flags(input string tag);
    chk(room_ok,    exp_room(),  {"R3 ", tag});
    chk(half_room,  exp_half(),  {"R4 ", tag});
    chk(need_upper, mpos[0],     {"R5 ", tag});
    chk(need_left,  !mpos[1],    {"R6 ", tag});
    chk(underrun,   m_un,        {"R9/R10 underrun ", tag});
    chk(frame_valid, m_fv,       {"R8 strobe ", tag});
  endtask

  task automatic cyc(input bit we, input logic [7:0] d, input bit tk);
    bit pop, push;
    wr_en = we; wr_data = d; tick = tk;
    pop  = tk && q.size() >= 4;
    push = we && q.size() < 64;
    if (pop) begin
      m_frame = {q[1], q[0], q[3], q[2]};
      m_last = m_frame;
      repeat (4) void'(q.pop_front());
    end else if (tk) begin
      m_frame = repeat_mode ? m_last : 32'h0;
    end
    if (tk && !pop) m_un = 1;
    if (push) begin
      if (mpos == 3) m_un = 0;
      q.push_back(d);
      mpos = (mpos + 1) % 4;
    end
    m_fv = tk;
    @(posedge clk); @(negedge clk);
    wr_en = 0; tick = 0;
    check_flags("cycle");
    if (tk) chk(frame_out, m_frame,
      pop ? "R2/R8 released frame" : (repeat_mode ? "R12 repeat fallback" : "R11 midscale fallback"));
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(room_ok, 1, "R1 room"); chk(half_room, 1, "R1 half");
    chk(need_upper, 0, "R1 upper"); chk(need_left, 1, "R1 left");
    chk(underrun, 0, "R1 underrun"); chk(frame_valid, 0, "R1 strobe");
    chk(frame_out, 0, "R1 frame");

    // one known frame, byte order
    cyc(1, 8'h11, 0); cyc(1, 8'h22, 0); cyc(1, 8'h33, 0); cyc(1, 8'h44, 0);
    cyc(0, 0, 1);
    chk(frame_out, 32'h2211_4433, "R2 byte order");
    // starve with midscale, then repeat
    repeat_mode = 0; cyc(0, 0, 1);
    chk(underrun, 1, "R9 set on starved tick");
    chk(frame_out, 0, "R11 midscale");
    repeat_mode = 1; cyc(0, 0, 1);
    chk(frame_out, 32'h2211_4433, "R12 repeat last");
    // fourth byte coincident with starved tick: clear wins
    cyc(1, 8'ha1, 0); cyc(1, 8'ha2, 0); cyc(1, 8'ha3, 0); cyc(1, 8'ha4, 1);
    chk(underrun, 0, "R10 clear wins");
    cyc(0, 0, 1);
    // fill to full, then extra writes ignored
    for (int i = 0; i < 70; i++) cyc(1, 8'(i + 8'h40), 0);
    chk(room_ok, 0, "R7 full room"); chk(need_upper, 0, "R7 position");
    cyc(1, 8'hee, 0); cyc(1, 8'hef, 0);
    for (int i = 0; i < 17; i++) cyc(0, 0, 1);
    chk(underrun, 1, "R9 after drain");

    for (int ph = 0; ph < 8; ph++) begin
      int wp = (ph % 2 == 0) ? 80 : 30;
      int tp = (ph % 2 == 0) ? 10 : 40;
      repeat_mode = ph[1];
      for (int n = 0; n < 600; n++)
        cyc(($urandom % 100) < wp, 8'($urandom), ($urandom % 100) < tp);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule